// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the strobe-capture front end of a parallel NOR-style flash bank. Each time the front end reports a finished bus write (an address and a data byte), the decoder advances a small sequence state machine. A byte program needs a three-write unlock prefix followed by a write that carries the target address and byte. A sector erase or a whole-bank erase needs a six-write prefix. When a sequence completes, the decoder issues a single-clock launch strobe to the internal operation timer, together with the operation kind and the latched target address and data.

The decoder also keeps the identification-mode flag used by the read path. While that flag is set, it supplies the two identification bytes. Any write that breaks a sequence drops the decoder back to plain read mode. While the timer reports an internal program or erase in progress, every write is ignored and the sequence state is frozen.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_start` is 0, `op_kind` is 0 (none), `id_mode` is 0 and `id_rd_data` is 00h.
- R2: The writes 5555h/AAh, 2AAAh/55h and 5555h/A0h, followed by any write A/D, give `op_start`=1 in the clock after that fourth write. In that same clock, `op_kind`=1 (program), `op_addr`=A and `op_data`=D.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh and 2AAAh/55h, followed by a write with data 30h at address A, launch `op_kind`=2 (sector erase). `op_addr` is then A with bits 11..0 cleared (4 KB sectors chosen by bits 17..12), and `op_data`=30h.
- R4: The same five-write erase prefix, followed by 5555h/10h, launches `op_kind`=3 (bank erase) with `op_addr`=0 and `op_data`=10h.
- R5: A write that does not match the next expected step returns the decoder to idle. A later sequence must start again from its first write.
- R6: While `busy` is 1, writes have no effect. No launch happens, `id_mode` does not change, and a partly entered sequence resumes where it stopped once `busy` falls.
- R7: The write 5555h/90h after the two unlock writes sets `id_mode`. While `id_mode` is set, `id_rd_data` is BFh for `rd_addr`=0, 19h for `rd_addr`=1 and 00h for any other address. While `id_mode` is clear, `id_rd_data` is 00h.
- R8: `id_mode` is cleared by the unlock writes followed by 5555h/F0h, or by a single write of F0h at any address. The one exception is the target write of a program.
- R9: `op_start` is never high in two consecutive clocks, and it is high only in the clock after an accepted write.
- R10: Address matching uses only address bits 14..0. Bits 17..15 of the command addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-clock strobe: a bus write has completed |
| wr_addr | input | 18 | Address of the completed write |
| wr_data | input | 8 | Data of the completed write |
| busy | input | 1 | Internal program or erase in progress |
| rd_addr | input | 18 | Read address from the read path |
| op_start | output | 1 | One-clock launch strobe to the operation timer |
| op_kind | output | 2 | 1 program, 2 sector erase, 3 bank erase |
| op_addr | output | 18 | Latched target address (sector base for erase) |
| op_data | output | 8 | Latched data byte |
| id_mode | output | 1 | Identification mode active |
| id_rd_data | output | 8 | Identification byte for `rd_addr` |

## Verification
The sequence machine is driven with complete program, sector-erase and bank-erase sequences. Each launch record is queued and compared, which separates the three final-step decodes and shows that the sector address is masked. Broken sequences with a wrong data byte, a wrong address or a wrong erase suffix show that the decoder aborts and does not resume from a later step. Writes made while busy show the difference between freezing the state and discarding it. Aliased command addresses exercise the 15-bit match, and the two exit forms and reads at three addresses exercise the identification path.

// File: rtl/fcd_pkg.sv
// Shared types and command codes for the flash command decoder.
// Assumes 8-bit data; address widths are set by module parameters.
package fcd_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_BANK = 2'd3
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERA3,
        ST_ERA4,
        ST_ERA5
    } seq_st_t;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [7:0] CD_UNL_A  = 8'hAA;
    localparam logic [7:0] CD_UNL_B  = 8'h55;
    localparam logic [7:0] CD_PROG   = 8'hA0;
    localparam logic [7:0] CD_ERASE  = 8'h80;
    localparam logic [7:0] CD_ID_IN  = 8'h90;
    localparam logic [7:0] CD_ID_OUT = 8'hF0;
    localparam logic [7:0] CD_SECT   = 8'h30;
    localparam logic [7:0] CD_BANK   = 8'h10;

    localparam logic [7:0] ID_MFR = 8'hBF;
    localparam logic [7:0] ID_DEV = 8'h19;

    // Per-write decode flags produced by the cycle matcher
    typedef struct packed {
        logic at_a;
        logic at_b;
        logic unl_a;
        logic unl_b;
        logic prog;
        logic erase;
        logic id_in;
        logic id_out;
        logic sect;
        logic bank;
    } cyc_match_t;

endpackage

// File: rtl/fcd_cycle_match.sv
// Decodes one bus write against the command address keys and code bytes.
// Assumes only the low MATCH_W address bits take part in key matching.
module fcd_cycle_match
    import fcd_pkg::*;
#(
    parameter int MATCH_W = 15,
    parameter int DATA_W  = 8
) (
    input  logic [MATCH_W-1:0] addr_lo,
    input  logic [DATA_W-1:0]  data,
    output cyc_match_t         m
);
    localparam logic [MATCH_W-1:0] KA = KEY_ADDR_A[MATCH_W-1:0];
    localparam logic [MATCH_W-1:0] KB = KEY_ADDR_B[MATCH_W-1:0];

    // Compare address and data against every known key and code
    always_comb begin
        m.at_a   = (addr_lo == KA);
        m.at_b   = (addr_lo == KB);
        m.unl_a  = (data == CD_UNL_A);
        m.unl_b  = (data == CD_UNL_B);
        m.prog   = (data == CD_PROG);
        m.erase  = (data == CD_ERASE);
        m.id_in  = (data == CD_ID_IN);
        m.id_out = (data == CD_ID_OUT);
        m.sect   = (data == CD_SECT);
        m.bank   = (data == CD_BANK);
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
// Sequence tracker: advances one step for each accepted write, aborts to
// idle on a mismatch, and holds all state while busy is high.
// Owns the identification-mode flag. Launch outputs are combinational.
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic       busy,
    input  cyc_match_t m,
    output logic       launch,
    output op_kind_t   launch_kind,
    output logic       id_mode
);
    seq_st_t st_q, st_d;
    logic    id_d;
    logic    take;

    assign take = wr_valid && !busy;

    // Next-state, launch and ID-flag decision for the current write
    always_comb begin
        st_d        = st_q;
        id_d        = id_mode;
        launch      = 1'b0;
        launch_kind = OP_NONE;
        if (take) begin
            st_d = ST_IDLE;
            unique case (st_q)
                ST_IDLE: if (m.at_a && m.unl_a) st_d = ST_UNL1;
                ST_UNL1: if (m.at_b && m.unl_b) st_d = ST_UNL2;
                ST_UNL2: begin
                    if (m.at_a && m.prog)       st_d = ST_PROG;
                    else if (m.at_a && m.erase) st_d = ST_ERA3;
                    else if (m.at_a && m.id_in) id_d = 1'b1;
                end
                ST_PROG: begin
                    launch      = 1'b1;
                    launch_kind = OP_PROG;
                end
                ST_ERA3: if (m.at_a && m.unl_a) st_d = ST_ERA4;
                ST_ERA4: if (m.at_b && m.unl_b) st_d = ST_ERA5;
                ST_ERA5: begin
                    if (m.sect) begin
                        launch      = 1'b1;
                        launch_kind = OP_SECT;
                    end else if (m.at_a && m.bank) begin
                        launch      = 1'b1;
                        launch_kind = OP_BANK;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
            // Any F0h write leaves ID mode, except a program target byte
            if (m.id_out && st_q != ST_PROG) begin
                id_d = 1'b0;
                st_d = ST_IDLE;
            end
        end
    end

    // State and ID flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            id_mode <= 1'b0;
        end else begin
            st_q    <= st_d;
            id_mode <= id_d;
        end
    end
endmodule

// File: rtl/fcd_op_latch.sv
// Registers the launch strobe and the operation record for the timer.
// Erase addresses are reduced to a sector base or to zero here.
module fcd_op_latch
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int SECT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  op_kind_t          kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              op_start,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    localparam logic [ADDR_W-1:0] SECT_MASK = {{(ADDR_W-SECT_W){1'b1}}, {SECT_W{1'b0}}};

    logic [ADDR_W-1:0] tgt_addr;

    // Pick the target address the timer should see for this kind
    always_comb begin
        unique case (kind)
            OP_SECT: tgt_addr = addr & SECT_MASK;
            OP_BANK: tgt_addr = '0;
            default: tgt_addr = addr;
        endcase
    end

    // Single-clock strobe plus held operation record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= launch;
            if (launch) begin
                op_kind <= kind;
                op_addr <= tgt_addr;
                op_data <= data;
            end
        end
    end
endmodule

// File: rtl/fcd_id_rom.sv
// Identification byte source for the read path: manufacturer byte at
// address 0, device byte at address 1, zero elsewhere or when not in ID mode.
module fcd_id_rom
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_rd_data
);
    // Address-indexed ID byte lookup
    always_comb begin
        id_rd_data = '0;
        if (id_mode) begin
            if (rd_addr == ADDR_W'(0))      id_rd_data = ID_MFR;
            else if (rd_addr == ADDR_W'(1)) id_rd_data = ID_DEV;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top level: protected command sequence decoder for a NOR-style flash bank.
// Assumes wr_valid is a one-clock pulse per completed bus write and that
// busy is driven by the operation timer for the length of each operation.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 8,
    parameter int MATCH_W = 15,
    parameter int SECT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_rd_data
);
    cyc_match_t match;
    logic       launch;
    op_kind_t   launch_kind;
    op_kind_t   kind_q;

    fcd_cycle_match #(.MATCH_W(MATCH_W), .DATA_W(DATA_W)) u_match (
        .addr_lo (wr_addr[MATCH_W-1:0]),
        .data    (wr_data),
        .m       (match)
    );

    fcd_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .busy        (busy),
        .m           (match),
        .launch      (launch),
        .launch_kind (launch_kind),
        .id_mode     (id_mode)
    );

    fcd_op_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .kind     (launch_kind),
        .addr     (wr_addr),
        .data     (wr_data),
        .op_start (op_start),
        .op_kind  (kind_q),
        .op_addr  (op_addr),
        .op_data  (op_data)
    );

    assign op_kind = kind_q;

    fcd_id_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_id (
        .id_mode    (id_mode),
        .rd_addr    (rd_addr),
        .id_rd_data (id_rd_data)
    );
endmodule

// File: rtl/fcd_checker.sv
// Temporal checks on the decoder ports, attached to every instance by bind.
module fcd_checker #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int SECT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              busy,
    input logic              op_start,
    input logic [1:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic              id_mode,
    input logic [DATA_W-1:0] id_rd_data
);
    // R9
    start_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    // R9
    start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wr_valid && !busy));

    // R6
    busy_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> (!op_start && id_mode == $past(id_mode)));

    // R3
    sector_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd2) |-> (op_addr[SECT_W-1:0] == '0));

    // R4
    bank_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd3) |-> (op_addr == '0));

    // R2
    start_has_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (op_kind != 2'd0));

    // R7
    id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> (id_rd_data == '0));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .busy       (busy),
    .op_start   (op_start),
    .op_kind    (op_kind),
    .op_addr    (op_addr),
    .id_mode    (id_mode),
    .id_rd_data (id_rd_data)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 18;

    typedef struct packed {
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } op_rec_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          op_start;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic          id_mode;
    logic [7:0]    id_rd_data;

    int      n_checks = 0;
    int      n_fails = 0;
    string   cur_req = "R1";
    op_rec_t exp_q[$];
    logic    prev_start = 1'b0;
    bit      finished = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr), .op_start(op_start),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .id_mode(id_mode), .id_rd_data(id_rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one accepted-write strobe per call, inputs changed at negedge
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_op(input logic [1:0] k, input logic [AW-1:0] a, input logic [7:0] d);
        op_rec_t r;
        r.kind = k;
        r.addr = a;
        r.data = d;
        exp_q.push_back(r);
    endtask

    task automatic unlock();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(18'h05555, 8'h80);
        unlock();
    endtask

    task automatic check_id(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        check(id_rd_data == exp, req, "id_rd_data", id_rd_data, exp);
    endtask

    // Monitor: compares every launch against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (op_start && prev_start)
                check(1'b0, "R9", "op_start two clocks", 2, 1);
            if (op_start) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected op_start kind", op_kind, 0);
                end else begin
                    op_rec_t r;
                    r = exp_q.pop_front();
                    check(op_kind == r.kind && op_addr == r.addr && op_data == r.data,
                          cur_req, "launch record", {op_kind, op_addr, op_data},
                          {r.kind, r.addr, r.data});
                end
            end
            prev_start = op_start;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(op_start == 1'b0, "R1", "op_start", op_start, 0);
        check(op_kind == 2'd0, "R1", "op_kind", op_kind, 0);
        check(id_mode == 1'b0, "R1", "id_mode", id_mode, 0);
        check_id(18'h0, 8'h00, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2 byte program
        cur_req = "R2";
        unlock();
        wr(18'h05555, 8'hA0);
        expect_op(2'd1, 18'h12345, 8'h5A);
        wr(18'h12345, 8'h5A);
        @(negedge clk);
        // R9 strobe gone one clock later
        check(op_start == 1'b0, "R9", "op_start width", op_start, 0);

        // R3 sector erase
        cur_req = "R3";
        erase_prefix();
        expect_op(2'd2, 18'h37000, 8'h30);
        wr(18'h37ABC, 8'h30);

        // R4 bank erase
        cur_req = "R4";
        erase_prefix();
        expect_op(2'd3, 18'h0, 8'h10);
        wr(18'h05555, 8'h10);

        // R5 aborts: wrong code, wrong address, wrong erase suffix
        cur_req = "R5";
        unlock();
        wr(18'h05555, 8'h77);
        wr(18'h05555, 8'hA0);
        wr(18'h00100, 8'h33);
        wr(18'h05555, 8'hAA);
        wr(18'h01234, 8'h55);
        wr(18'h05555, 8'hA0);
        wr(18'h00200, 8'h44);
        erase_prefix();
        wr(18'h05555, 8'h20);
        wr(18'h05555, 8'h10);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5", "pending launches", exp_q.size(), 0);

        // R6 full sequence while busy is ignored
        cur_req = "R6";
        busy = 1'b1;
        unlock();
        wr(18'h05555, 8'hA0);
        wr(18'h00300, 8'h66);
        unlock();
        wr(18'h05555, 8'h90);
        check(id_mode == 1'b0, "R6", "id_mode under busy", id_mode, 0);
        busy = 1'b0;
        wr(18'h00300, 8'h66);
        // R6 partial sequence freezes, then resumes
        unlock();
        busy = 1'b1;
        wr(18'h00000, 8'h00);
        busy = 1'b0;
        wr(18'h05555, 8'hA0);
        expect_op(2'd1, 18'h00400, 8'h99);
        wr(18'h00400, 8'h99);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6", "resumed launch", exp_q.size(), 0);

        // R10 aliased command addresses
        cur_req = "R10";
        wr(18'h3D555, 8'hAA);
        wr(18'h2AAAA, 8'h55);
        wr(18'h15555, 8'hA0);
        expect_op(2'd1, 18'h00010, 8'hC3);
        wr(18'h00010, 8'hC3);

        // R7 ID entry and reads
        cur_req = "R7";
        unlock();
        wr(18'h05555, 8'h90);
        check(id_mode == 1'b1, "R7", "id_mode", id_mode, 1);
        check_id(18'h0, 8'hBF, "R7");
        check_id(18'h1, 8'h19, "R7");
        check_id(18'h2, 8'h00, "R7");

        // R8 single-write exit
        cur_req = "R8";
        wr(18'h00777, 8'hF0);
        check(id_mode == 1'b0, "R8", "id_mode after single F0", id_mode, 0);
        check_id(18'h0, 8'h00, "R8");

        // R6 exit ignored while busy
        unlock();
        wr(18'h05555, 8'h90);
        busy = 1'b1;
        wr(18'h00000, 8'hF0);
        busy = 1'b0;
        check(id_mode == 1'b1, "R6", "id_mode exit under busy", id_mode, 1);

        // R8 three-write exit
        unlock();
        wr(18'h05555, 8'hF0);
        check(id_mode == 1'b0, "R8", "id_mode after sequence exit", id_mode, 0);

        // R8 program target byte F0h does not leave ID mode
        unlock();
        wr(18'h05555, 8'h90);
        unlock();
        wr(18'h05555, 8'hA0);
        expect_op(2'd1, 18'h00020, 8'hF0);
        wr(18'h00020, 8'hF0);
        check(id_mode == 1'b1, "R8", "id_mode after F0 program byte", id_mode, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all launches seen", exp_q.size(), 0);
        finish_run();
    end
endmodule